// File: doc/BRIEF.md
# Receiver Polling Cycle Sequencer

This block drives a low-power receive loop that keeps the front end off most of the time. Each polling round passes through four phases in a fixed order. First comes a sleep interval with everything off. Next is a synthesizer start-up that waits for the PLL to lock. Then comes a signal-path warm-up of programmable length. Last is a bit-check window, in which outside logic judges whether a valid telegram is present. A failed check sends the sequencer back to sleep. A passing check raises a one-cycle pulse that hands the receiver over to full receive mode, and the loop stops there.

The sleep length is counted in ticks of a basic data clock, which arrive as a tick-enable input. The number of ticks is the 5-bit sleep value times a fixed prescale (1024 by default) times an extension multiplier. The multiplier is 1 when the extension select is low and 8 when it is high. The sequencer captures all configuration inputs at the start of every sleep phase, so software can rewrite them at any time without disturbing the round in progress. The radio, the demodulator and the bit-check logic are outside this block.

Top module: `rx_poll_sequencer`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in the sleep phase (phase code 0), clears its counters and drives pll_en, sigproc_en and rx_enter low.
- R2: The phase code on phase_o only ever advances as sleep (0) to PLL start-up (1) to signal-path start-up (2) to bit-check (3), then either back to sleep (0) or on to receive (4).
- R3: The sleep phase ends after exactly cfg_sleep × PRESCALE × M tick-enabled cycles, where M is 1 when cfg_ext is 0 and EXT_MULT when cfg_ext is 1. The first sleep cycle, the cycle in which the phase ends, and cycles with tick_en low add no ticks.
- R4: A sleep value of zero makes a zero-length sleep: phase 0 lasts exactly two clock cycles and then phase 1 begins.
- R5: The PLL start-up phase lasts until pll_locked is sampled high. Phase 2 and sigproc_en begin only in the cycle after that sample.
- R6: The signal-path start-up phase ends after exactly cfg_su_len tick-enabled cycles, not counting the cycle in which it ends. A value of zero moves to bit-check after one cycle.
- R7: pll_en is low in sleep and high in phases 1 to 4. sigproc_en is high only in phases 2 to 4. The receiver is therefore insensitive during sleep and both start-up phases.
- R8: In bit-check, chk_valid with chk_pass high moves the sequencer to phase 4 and raises rx_enter for exactly one cycle. Phase 4 then holds until reset, whatever the inputs do.
- R9: In bit-check, chk_valid with chk_pass low returns the sequencer to sleep, with pll_en and sigproc_en low in the next cycle.
- R10: The configuration inputs are captured only in the first cycle of each sleep phase. Changes at any other time do not affect the current round.
- R11: chk_valid and chk_pass have no effect outside the bit-check phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One basic data-clock tick in this cycle |
| pll_locked | input | 1 | Synthesizer lock indication |
| chk_valid | input | 1 | Bit-check outcome is present this cycle |
| chk_pass | input | 1 | Bit-check outcome: 1 = valid telegram |
| cfg_sleep | input | SLEEP_W | Sleep length in units of PRESCALE ticks |
| cfg_ext | input | 1 | Sleep extension select (0: ×1, 1: ×EXT_MULT) |
| cfg_su_len | input | SU_W | Signal-path start-up length in ticks |
| phase_o | output | 3 | Current phase: 0 sleep, 1 PLL start-up, 2 signal-path start-up, 3 bit-check, 4 receive |
| pll_en | output | 1 | Synthesizer enable |
| sigproc_en | output | 1 | Signal-processing enable |
| rx_enter | output | 1 | One-cycle pulse on a passing bit-check |

## Verification
The assertions check on every cycle that the phase changes only along legal edges. They also check that signal processing never runs without the PLL enable, that the signal path starts only after a sampled lock, that the receive pulse lasts a single cycle, that the receive phase holds, and that the tick counters step by one on a tick. Exact tick counts cannot be seen cycle by cycle: the sleep product with and without extension, the zero-length sleep and the warm-up length. Neither can the rule that configuration is captured only at sleep entry. The bench's scenarios show these. They count ticks per phase under random tick densities while scrambling the configuration inputs and toggling the check inputs outside the bit-check phase.

// File: rtl/rx_poll_pkg.sv
package rx_poll_pkg;

  typedef enum logic [2:0] {
    PH_SLEEP = 3'd0,
    PH_PLL   = 3'd1,
    PH_SIG   = 3'd2,
    PH_CHK   = 3'd3,
    PH_RX    = 3'd4
  } poll_phase_e;

  // Legal phase changes of the polling loop.
  function automatic logic legal_step(poll_phase_e from_ph, poll_phase_e to_ph);
    logic ok;
    ok = 1'b0;
    case (from_ph)
      PH_SLEEP: ok = (to_ph == PH_PLL);
      PH_PLL:   ok = (to_ph == PH_SIG);
      PH_SIG:   ok = (to_ph == PH_CHK);
      PH_CHK:   ok = (to_ph == PH_SLEEP) || (to_ph == PH_RX);
      default:  ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/poll_tick_counter.sv
module poll_tick_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] target,
  output logic         done
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (tick && (cnt != target)) begin
      cnt <= cnt + W'(1);
    end
  end

  assign done = (cnt == target);

  // R3 / R6: while counting, the count never passes its target
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    !clr |-> (cnt <= target));

  // R3 / R6: a change of count outside a clear is a single step on a tick
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(clr) && !$past(rst) && (cnt != $past(cnt)))
      |-> ((cnt == $past(cnt) + W'(1)) && $past(tick)));

endmodule

// File: rtl/poll_cfg_shadow.sv
module poll_cfg_shadow #(
  parameter int SLEEP_W  = 5,
  parameter int SU_W     = 4,
  parameter int PRESCALE = 1024,
  parameter int EXT_MULT = 8,
  parameter int CNT_W    = 19
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [SLEEP_W-1:0] cfg_sleep,
  input  logic               cfg_ext,
  input  logic [SU_W-1:0]    cfg_su_len,
  output logic [CNT_W-1:0]   slp_target,
  output logic [SU_W-1:0]    su_target
);

  localparam bit PRE_POW2 = ((PRESCALE & (PRESCALE - 1)) == 0);
  localparam int PRE_SH   = $clog2(PRESCALE);

  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] full;

  generate
    if (PRE_POW2) begin : g_shift
      always_comb base = CNT_W'(cfg_sleep) << PRE_SH;
    end else begin : g_mult
      always_comb base = CNT_W'(cfg_sleep) * CNT_W'(PRESCALE);
    end
  endgenerate

  always_comb full = cfg_ext ? (base * CNT_W'(EXT_MULT)) : base;

  always_ff @(posedge clk) begin
    if (rst) begin
      slp_target <= '0;
      su_target  <= '0;
    end else if (load) begin
      slp_target <= full;
      su_target  <= cfg_su_len;
    end
  end

  // R10: captured values change only in a load cycle
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(load) && !$past(rst) |-> ($stable(slp_target) && $stable(su_target)));

endmodule

// File: rtl/rx_poll_sequencer.sv
module rx_poll_sequencer
  import rx_poll_pkg::*;
#(
  parameter int SLEEP_W  = 5,
  parameter int PRESCALE = 1024,
  parameter int EXT_MULT = 8,
  parameter int SU_W     = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_en,
  input  logic               pll_locked,
  input  logic               chk_valid,
  input  logic               chk_pass,
  input  logic [SLEEP_W-1:0] cfg_sleep,
  input  logic               cfg_ext,
  input  logic [SU_W-1:0]    cfg_su_len,
  output logic [2:0]         phase_o,
  output logic               pll_en,
  output logic               sigproc_en,
  output logic               rx_enter
);

  localparam int CNT_W = SLEEP_W + $clog2(PRESCALE) + $clog2(EXT_MULT) + 1;

  poll_phase_e      state, nxt;
  logic             load_q;
  logic [CNT_W-1:0] slp_target;
  logic [SU_W-1:0]  su_target;
  logic             slp_done, su_done;
  logic             slp_clr, su_clr;

  poll_cfg_shadow #(
    .SLEEP_W (SLEEP_W),
    .SU_W    (SU_W),
    .PRESCALE(PRESCALE),
    .EXT_MULT(EXT_MULT),
    .CNT_W   (CNT_W)
  ) u_shadow (
    .clk       (clk),
    .rst       (rst),
    .load      (load_q),
    .cfg_sleep (cfg_sleep),
    .cfg_ext   (cfg_ext),
    .cfg_su_len(cfg_su_len),
    .slp_target(slp_target),
    .su_target (su_target)
  );

  assign slp_clr = load_q || (state != PH_SLEEP);
  assign su_clr  = (state != PH_SIG);

  poll_tick_counter #(.W(CNT_W)) u_sleep_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr   (slp_clr),
    .tick  (tick_en),
    .target(slp_target),
    .done  (slp_done)
  );

  poll_tick_counter #(.W(SU_W)) u_su_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr   (su_clr),
    .tick  (tick_en),
    .target(su_target),
    .done  (su_done)
  );

  always_comb begin
    nxt = state;
    case (state)
      PH_SLEEP: if (!load_q && slp_done) nxt = PH_PLL;
      PH_PLL:   if (pll_locked)          nxt = PH_SIG;
      PH_SIG:   if (su_done)             nxt = PH_CHK;
      PH_CHK:   if (chk_valid)           nxt = chk_pass ? PH_RX : PH_SLEEP;
      default:                           nxt = PH_RX;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= PH_SLEEP;
      load_q     <= 1'b1;
      pll_en     <= 1'b0;
      sigproc_en <= 1'b0;
      rx_enter   <= 1'b0;
    end else begin
      state      <= nxt;
      load_q     <= (nxt == PH_SLEEP) && (state != PH_SLEEP);
      pll_en     <= (nxt != PH_SLEEP);
      sigproc_en <= (nxt == PH_SIG) || (nxt == PH_CHK) || (nxt == PH_RX);
      rx_enter   <= (state == PH_CHK) && (nxt == PH_RX);
    end
  end

  assign phase_o = state;

  // R1: one cycle after reset the loop sits in sleep with the PLL off
  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> ((state == PH_SLEEP) && !pll_en && !sigproc_en && !rx_enter));

  // R2: only legal phase steps
  p_order_r2: assert property (@(posedge clk) disable iff (rst)
    (state != $past(state)) && !$past(rst) |-> legal_step($past(state), state));

  // R3: sleep is left only once the sleep count is reached, never in the load cycle
  p_sleep_exit_r3: assert property (@(posedge clk) disable iff (rst)
    (state == PH_PLL) && ($past(state) == PH_SLEEP) |-> ($past(slp_done) && !$past(load_q)));

  // R5: the signal path starts only after a sampled lock
  p_lock_gate_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(sigproc_en) |-> $past(pll_locked));

  // R7: signal processing never runs without the synthesizer
  p_enables_r7: assert property (@(posedge clk) disable iff (rst)
    sigproc_en |-> pll_en);

  // R7: sleep keeps everything off
  p_sleep_off_r7: assert property (@(posedge clk) disable iff (rst)
    (state == PH_SLEEP) |-> (!pll_en && !sigproc_en));

  // R8: the handover pulse lasts one cycle
  p_rx_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rx_enter |=> !rx_enter);

  // R8: receive phase holds until reset
  p_halt_r8: assert property (@(posedge clk) disable iff (rst)
    (state == PH_RX) |=> (state == PH_RX));

  // R8 / R11: receive is reached only from a passing check
  p_rx_entry_r11: assert property (@(posedge clk) disable iff (rst)
    (state == PH_RX) && ($past(state) != PH_RX) && !$past(rst)
      |-> (($past(state) == PH_CHK) && $past(chk_valid) && $past(chk_pass)));

endmodule

// File: tb/rx_poll_sequencer_tb_top.sv
module rx_poll_sequencer_tb_top;

  localparam int SW  = 5;
  localparam int PRE = 4;
  localparam int EXT = 8;
  localparam int SUW = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           tick_en = 1'b0;
  logic           pll_locked = 1'b0;
  logic           chk_valid = 1'b0;
  logic           chk_pass = 1'b0;
  logic [SW-1:0]  cfg_sleep = '0;
  logic           cfg_ext = 1'b0;
  logic [SUW-1:0] cfg_su_len = '0;
  logic [2:0]     phase_o;
  logic           pll_en, sigproc_en, rx_enter;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  rx_poll_sequencer #(
    .SLEEP_W(SW), .PRESCALE(PRE), .EXT_MULT(EXT), .SU_W(SUW)
  ) dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .pll_locked(pll_locked),
    .chk_valid(chk_valid), .chk_pass(chk_pass), .cfg_sleep(cfg_sleep),
    .cfg_ext(cfg_ext), .cfg_su_len(cfg_su_len), .phase_o(phase_o),
    .pll_en(pll_en), .sigproc_en(sigproc_en), .rx_enter(rx_enter)
  );

  function automatic int exp_sleep(input int f, input int ext);
    return f * PRE * (ext != 0 ? EXT : 1);
  endfunction

  function automatic logic rnd(input int pct);
    return (($urandom % 100) < pct);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic scramble();
    cfg_sleep  = SW'($urandom);
    cfg_ext    = 1'($urandom);
    cfg_su_len = SUW'($urandom);
  endtask

  // Ends at a falling edge with rst just released; the next cycle is the first sleep cycle.
  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(phase_o == 3'd0 && !pll_en && !sigproc_en && !rx_enter,
          "R1 reset state", {phase_o, pll_en, sigproc_en, rx_enter}, 0);
    rst = 1'b0;
  endtask

  // Called at the falling edge of the first sleep cycle.
  task automatic poll(input int f, input int ext, input int su, input int lockd,
                      input bit pass, input int tp);
    int ticks, last_t, nsc, guard;
    bit first, bad;
    logic t;
    ticks = 0; last_t = 0; nsc = 0; guard = 0; first = 1'b1; bad = 1'b0;
    check(phase_o == 3'd0, "R2 round starts in sleep", phase_o, 0);
    cfg_sleep = SW'(f); cfg_ext = 1'(ext); cfg_su_len = SUW'(su);
    pll_locked = 1'b0;
    // sleep phase
    while (phase_o == 3'd0 && guard < 20000) begin
      t = rnd(tp);
      tick_en = t;
      chk_valid = rnd(50); chk_pass = 1'b1;           // R11 stimulus
      if (!first) begin
        ticks += int'(t); last_t = int'(t); nsc++;
        scramble();                                     // R10 stimulus
      end
      if (pll_en || sigproc_en) bad = 1'b1;
      first = 1'b0;
      guard++;
      @(negedge clk);
    end
    check(!bad, "R7 enables low in sleep", int'(bad), 0);
    check(ticks - last_t == exp_sleep(f, ext), "R3/R10 sleep tick count",
          ticks - last_t, exp_sleep(f, ext));
    if (exp_sleep(f, ext) == 0)
      check(nsc + 1 == 2, "R4 zero sleep lasts two cycles", nsc + 1, 2);
    check(phase_o == 3'd1, "R2 sleep then PLL start-up", phase_o, 1);
    // PLL start-up phase
    bad = 1'b0;
    for (int i = 0; i < lockd; i++) begin
      if (phase_o != 3'd1 || !pll_en || sigproc_en) bad = 1'b1;
      pll_locked = 1'b0; chk_valid = rnd(50); tick_en = rnd(tp); scramble();
      @(negedge clk);
    end
    check(!bad && phase_o == 3'd1, "R5 waits for lock", phase_o, 1);
    pll_locked = 1'b1;
    @(negedge clk);
    check(phase_o == 3'd2 && sigproc_en && pll_en, "R5/R7 signal path after lock",
          {phase_o, sigproc_en}, 5);
    // signal-path start-up
    ticks = 0; last_t = 0; guard = 0;
    while (phase_o == 3'd2 && guard < 1000) begin
      t = rnd(tp);
      tick_en = t;
      ticks += int'(t); last_t = int'(t);
      chk_valid = rnd(50); scramble();
      guard++;
      @(negedge clk);
    end
    check(ticks - last_t == su, "R6/R10 start-up tick count", ticks - last_t, su);
    check(phase_o == 3'd3 && pll_en && sigproc_en, "R2 start-up then bit-check", phase_o, 3);
    // bit-check window
    chk_valid = 1'b0;
    repeat (2) begin
      scramble();
      @(negedge clk);
    end
    check(phase_o == 3'd3, "R11 bit-check waits for outcome", phase_o, 3);
    chk_valid = 1'b1; chk_pass = pass;
    @(negedge clk);
    chk_valid = 1'b0;
    if (pass) begin
      check(phase_o == 3'd4 && rx_enter, "R8 pass enters receive", {phase_o, rx_enter}, 9);
      chk_valid = 1'b1; chk_pass = 1'b0;
      @(negedge clk);
      check(!rx_enter, "R8 pulse is one cycle", int'(rx_enter), 0);
      repeat (5) begin
        chk_valid = rnd(50); chk_pass = rnd(50);
        @(negedge clk);
      end
      check(phase_o == 3'd4 && pll_en && sigproc_en, "R8 receive holds", phase_o, 4);
      chk_valid = 1'b0;
    end else begin
      check(phase_o == 3'd0 && !pll_en && !sigproc_en && !rx_enter,
            "R9 fail returns to sleep", {phase_o, pll_en, sigproc_en, rx_enter}, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int f, e, s, ld, tp;
    bit p;
    void'($urandom(32'h00c0ffee));
    do_reset();
    // directed corners
    poll(0, 0, 0, 0, 1'b0, 100);     // R4 zero sleep, R6 zero start-up
    poll(0, 1, 0, 2, 1'b0, 60);      // R4 zero sleep ignores extension
    poll(31, 0, 15, 3, 1'b0, 100);   // R3 maximum without extension
    poll(31, 1, 1, 1, 1'b0, 100);    // R3 maximum with extension
    poll(1, 0, 7, 5, 1'b0, 40);      // R3 sparse ticks
    poll(2, 1, 3, 0, 1'b1, 70);      // R8 pass
    do_reset();                      // R1 from receive
    // random rounds
    for (int k = 0; k < 24; k++) begin
      f  = int'($urandom % 32);
      e  = int'($urandom % 2);
      s  = int'($urandom % 16);
      ld = int'($urandom % 6);
      tp = 30 + int'($urandom % 71);
      p  = (k % 8 == 7);
      poll(f, e, s, ld, p, tp);
      if (p) do_reset();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule